// File: doc/BRIEF.md
# Home Directory Controller with DMA Coherence

This block is the home node for a set of cache lines under a two-state coherence scheme, where each line is either invalid in all caches or held modified by exactly one cache. For every line it keeps a state and an owner ID. It takes processor fetch and put requests, DMA reads and writes, and memory completions on three separate inputs. In return it issues forwards, invalidates, writeback acknowledges and refusals, fill data, DMA data and acknowledges, and memory read and write commands.

Each input carries a valid flag and its fields. In each cycle the block serves at most one input. Memory completions are always consumed. A DMA or processor request is either consumed (`*_take`) or refused for now (`*_retry`). On a refusal the source moves the request to the back of its queue, so no request stalls the block. A four-entry associative table holds the extra context of lines that are in flight: DMA requestor, DMA payload, byte offset and length, and old owner. A DMA access to a line that a cache holds modified first invalidates the owner. It then waits for the owner's put, and merges any DMA bytes over the returned line before the writeback.

Top module: `dir_ctrl`

## Requirements
- R1: After reset every line is invalid, the in-flight table is empty and no output valid (`fwd_valid`, `rsp_valid`, `dmr_valid`, `mc_valid`) is high.
- R2: A put (`cpu_op`=2) from a source that is not the recorded owner of a line in the invalid or modified state is consumed and answered with a refusal (`fwd_kind`=3) to that source. The line state does not change.
- R3: A fetch (`cpu_op`=0 or 1, both handled alike) to an invalid line issues a memory read (`mc_write`=0) and records the requestor as owner. The memory data (`mem_ack`=0) is then sent on `rsp_*` to that owner, and the line becomes modified.
- R4: A fetch to a modified line is forwarded (`fwd_kind`=0) to the current owner, with `fwd_req` set to the new requestor. The new requestor becomes the owner.
- R5: A put from the owner of a modified line issues a full-line memory write (`mc_be` all ones) of the put data. The following memory acknowledge (`mem_ack`=1) returns a writeback acknowledge (`fwd_kind`=2) to that owner, and the line becomes invalid.
- R6: A DMA read of an invalid line issues a memory read. The returned data goes to the DMA requestor as a full line on `dmr_*` with `dmr_ack`=0, and the line becomes invalid.
- R7: A DMA write of an invalid line issues a memory write of `dma_data` whose byte enable `mc_be` has bit b set exactly for offset <= b < offset+length, with bytes past the line end dropped. The memory acknowledge returns a DMA acknowledge (`dmr_ack`=1) to the DMA requestor.
- R8: A DMA access to a modified line sends an invalidate (`fwd_kind`=1) to the owner. On a DMA read, the owner's put data is sent to the DMA requestor and written to memory. On a DMA write, the memory write carries the put data with the DMA bytes laid over it.
- R9: A request that arrives while its line is in any transient state is refused with `*_retry`. The only exception is the owner's put to a line waiting on a DMA invalidate. A refused request produces no command or response.
- R10: After an owner's put that answers a DMA invalidate, the memory acknowledge returns a writeback acknowledge to that owner. For a DMA write, the same acknowledge also sends a DMA acknowledge to the DMA requestor. The line then becomes invalid.
- R11: A DMA request, or an owner put to a modified line, that needs a table entry while all TBE_N entries are busy is refused. An entry freed by a completion makes the same request succeed.
- R12: In one cycle a memory completion is served before a DMA request, and a DMA request before a processor request. An input that is not served sees neither take nor retry.
- R13: `rsp_*`, `dmr_*` and `mc_*` messages appear one clock edge after the accepting edge. `fwd_*` messages appear DIR_LAT edges after it (default 12).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_op | input | 2 | 0 shared fetch, 1 exclusive fetch, 2 put |
| cpu_src | input | CID_W | Requesting cache ID |
| cpu_addr | input | ADDR_W | Line address |
| cpu_data | input | LINE_B*8 | Put data |
| cpu_take | output | 1 | Processor request consumed this cycle |
| cpu_retry | output | 1 | Processor request refused, to be recycled |
| dma_valid | input | 1 | DMA request present |
| dma_write | input | 1 | 1 write, 0 read |
| dma_src | input | DID_W | DMA requestor ID |
| dma_addr | input | ADDR_W | Line address |
| dma_off | input | log2(LINE_B) | First byte of a write |
| dma_len | input | log2(LINE_B)+1 | Byte count of a write |
| dma_data | input | LINE_B*8 | Write data, byte b at bits 8b+7:8b |
| dma_take | output | 1 | DMA request consumed |
| dma_retry | output | 1 | DMA request refused, to be recycled |
| mem_valid | input | 1 | Memory completion present |
| mem_ack | input | 1 | 1 write acknowledge, 0 read data |
| mem_addr | input | ADDR_W | Line address of completion |
| mem_data | input | LINE_B*8 | Read data |
| fwd_valid | output | 1 | Delayed control message valid |
| fwd_kind | output | 2 | 0 forward, 1 invalidate, 2 writeback ack, 3 refusal |
| fwd_dst | output | CID_W | Destination cache |
| fwd_req | output | CID_W | New requestor (forward only) |
| fwd_addr | output | ADDR_W | Line address |
| rsp_valid | output | 1 | Fill data valid |
| rsp_dst | output | CID_W | Destination cache |
| rsp_addr | output | ADDR_W | Line address |
| rsp_data | output | LINE_B*8 | Line data |
| dmr_valid | output | 1 | DMA response valid |
| dmr_ack | output | 1 | 1 acknowledge, 0 data |
| dmr_dst | output | DID_W | DMA requestor |
| dmr_addr | output | ADDR_W | Line address |
| dmr_data | output | LINE_B*8 | Line data |
| mc_valid | output | 1 | Memory command valid |
| mc_write | output | 1 | 1 write, 0 read |
| mc_addr | output | ADDR_W | Line address |
| mc_data | output | LINE_B*8 | Write data |
| mc_be | output | LINE_B | Byte enables of a write |

## Verification
The bench drives DMA writes with offsets and lengths at both line ends, one that runs past the end, and one of zero length. A wrong range compare would show up as a shifted or oversized byte enable. It replays a DMA write that hits a modified line and compares the writeback with an independent merge model, so a design that wrote only the owner's data, or only the DMA bytes, is caught. It sends stale-owner puts, requests to lines in flight, simultaneous requests on all three inputs, and a fifth allocation while the table is full. A design with the wrong priority, or one that dropped or emitted messages while refusing, produces an unexpected take, a missing retry or a stray command. The control channel is sampled one cycle before and at its due cycle, which exposes a wrong delay.

// File: rtl/dir_ctrl.sv
module dir_ctrl #(
  parameter int ADDR_W  = 3,
  parameter int CID_W   = 2,
  parameter int DID_W   = 2,
  parameter int LINE_B  = 64,
  parameter int TBE_N   = 4,
  parameter int DIR_LAT = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cpu_valid,
  input  logic [1:0]                 cpu_op,
  input  logic [CID_W-1:0]           cpu_src,
  input  logic [ADDR_W-1:0]          cpu_addr,
  input  logic [LINE_B*8-1:0]        cpu_data,
  output logic                       cpu_take,
  output logic                       cpu_retry,
  input  logic                       dma_valid,
  input  logic                       dma_write,
  input  logic [DID_W-1:0]           dma_src,
  input  logic [ADDR_W-1:0]          dma_addr,
  input  logic [$clog2(LINE_B)-1:0]  dma_off,
  input  logic [$clog2(LINE_B):0]    dma_len,
  input  logic [LINE_B*8-1:0]        dma_data,
  output logic                       dma_take,
  output logic                       dma_retry,
  input  logic                       mem_valid,
  input  logic                       mem_ack,
  input  logic [ADDR_W-1:0]          mem_addr,
  input  logic [LINE_B*8-1:0]        mem_data,
  output logic                       fwd_valid,
  output logic [1:0]                 fwd_kind,
  output logic [CID_W-1:0]           fwd_dst,
  output logic [CID_W-1:0]           fwd_req,
  output logic [ADDR_W-1:0]          fwd_addr,
  output logic                       rsp_valid,
  output logic [CID_W-1:0]           rsp_dst,
  output logic [ADDR_W-1:0]          rsp_addr,
  output logic [LINE_B*8-1:0]        rsp_data,
  output logic                       dmr_valid,
  output logic                       dmr_ack,
  output logic [DID_W-1:0]           dmr_dst,
  output logic [ADDR_W-1:0]          dmr_addr,
  output logic [LINE_B*8-1:0]        dmr_data,
  output logic                       mc_valid,
  output logic                       mc_write,
  output logic [ADDR_W-1:0]          mc_addr,
  output logic [LINE_B*8-1:0]        mc_data,
  output logic [LINE_B-1:0]          mc_be
);
  localparam int LW  = LINE_B * 8;
  localparam int OW  = $clog2(LINE_B);
  localparam int NL  = 1 << ADDR_W;
  localparam int TIW = (TBE_N > 1) ? $clog2(TBE_N) : 1;
  localparam logic [1:0] K_FWD = 2'd0, K_INV = 2'd1, K_WBACK = 2'd2, K_NACK = 2'd3;

  typedef enum logic [3:0] {
    S_INV, S_MOD, S_FILL, S_EVICT, S_DRD, S_DWR, S_SNRD, S_SNWR, S_SNRD_WB, S_SNWR_WB
  } st_t;

  st_t              st  [NL];
  logic [CID_W-1:0] own [NL];

  logic [TBE_N-1:0] tv;
  logic [ADDR_W-1:0] ta [TBE_N];
  logic [DID_W-1:0] tdid [TBE_N];
  logic [CID_W-1:0] towner [TBE_N];
  logic [LW-1:0]    tdata [TBE_N];
  logic [OW-1:0]    toff [TBE_N];
  logic [OW:0]      tlen [TBE_N];

  logic              pv [DIR_LAT];
  logic [1:0]        pk [DIR_LAT];
  logic [CID_W-1:0]  pd [DIR_LAT];
  logic [CID_W-1:0]  pr [DIR_LAT];
  logic [ADDR_W-1:0] pa [DIR_LAT];

  function automatic logic [LINE_B-1:0] mask_b(input logic [OW-1:0] off, input logic [OW:0] len);
    mask_b = '0;
    for (int b = 0; b < LINE_B; b++)
      if (b >= int'(off) && b < int'(off) + int'(len)) mask_b[b] = 1'b1;
  endfunction

  function automatic logic [LW-1:0] merge_b(input logic [LW-1:0] base, input logic [LW-1:0] src,
                                            input logic [OW-1:0] off, input logic [OW:0] len);
    logic [LINE_B-1:0] m;
    m = mask_b(off, len);
    merge_b = base;
    for (int b = 0; b < LINE_B; b++)
      if (m[b]) merge_b[b*8 +: 8] = src[b*8 +: 8];
  endfunction

  st_t st_c, st_d, st_m;
  assign st_c = st[cpu_addr];
  assign st_d = st[dma_addr];
  assign st_m = st[mem_addr];

  logic free_ok;
  logic [TIW-1:0] free_i, hit_m, hit_c;
  always_comb begin
    free_ok = 1'b0;
    free_i  = '0;
    hit_m   = '0;
    hit_c   = '0;
    for (int i = TBE_N - 1; i >= 0; i--) begin
      if (!tv[i]) begin free_ok = 1'b1; free_i = i[TIW-1:0]; end
      if (tv[i] && ta[i] == mem_addr) hit_m = i[TIW-1:0];
      if (tv[i] && ta[i] == cpu_addr) hit_c = i[TIW-1:0];
    end
  end

  logic sel_d, sel_c, dma_ok, cpu_ok, is_put, put_ok, stable_c;
  assign sel_d    = dma_valid && !mem_valid;
  assign sel_c    = cpu_valid && !mem_valid && !dma_valid;
  assign dma_ok   = (st_d == S_INV || st_d == S_MOD) && free_ok;
  assign is_put   = cpu_op == 2'd2;
  assign stable_c = st_c == S_INV || st_c == S_MOD;
  assign put_ok   = own[cpu_addr] == cpu_src && (st_c == S_MOD || st_c == S_SNRD || st_c == S_SNWR);
  assign cpu_ok   = !is_put ? stable_c :
                    !put_ok ? stable_c :
                    (st_c == S_MOD) ? free_ok : 1'b1;
  assign dma_take  = sel_d && dma_ok;
  assign dma_retry = sel_d && !dma_ok;
  assign cpu_take  = sel_c && cpu_ok;
  assign cpu_retry = sel_c && !cpu_ok;

  assign fwd_valid = pv[DIR_LAT-1];
  assign fwd_kind  = pk[DIR_LAT-1];
  assign fwd_dst   = pd[DIR_LAT-1];
  assign fwd_req   = pr[DIR_LAT-1];
  assign fwd_addr  = pa[DIR_LAT-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NL; i++) begin st[i] <= S_INV; own[i] <= '0; end
      for (int j = 0; j < DIR_LAT; j++) pv[j] <= 1'b0;
      tv <= '0;
      rsp_valid <= 1'b0;
      dmr_valid <= 1'b0;
      mc_valid  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      dmr_valid <= 1'b0;
      mc_valid  <= 1'b0;
      pv[0]     <= 1'b0;
      for (int j = 1; j < DIR_LAT; j++) begin
        pv[j] <= pv[j-1]; pk[j] <= pk[j-1]; pd[j] <= pd[j-1]; pr[j] <= pr[j-1]; pa[j] <= pa[j-1];
      end
      if (mem_valid) begin
        case (st_m)
          S_FILL: if (!mem_ack) begin
            rsp_valid <= 1'b1; rsp_dst <= own[mem_addr]; rsp_addr <= mem_addr; rsp_data <= mem_data;
            st[mem_addr] <= S_MOD;
          end
          S_DRD: if (!mem_ack) begin
            dmr_valid <= 1'b1; dmr_ack <= 1'b0; dmr_dst <= tdid[hit_m]; dmr_addr <= mem_addr;
            dmr_data <= mem_data; tv[hit_m] <= 1'b0; st[mem_addr] <= S_INV;
          end
          S_DWR: if (mem_ack) begin
            dmr_valid <= 1'b1; dmr_ack <= 1'b1; dmr_dst <= tdid[hit_m]; dmr_addr <= mem_addr;
            tv[hit_m] <= 1'b0; st[mem_addr] <= S_INV;
          end
          S_EVICT, S_SNRD_WB, S_SNWR_WB: if (mem_ack) begin
            pv[0] <= 1'b1; pk[0] <= K_WBACK; pd[0] <= towner[hit_m]; pr[0] <= '0; pa[0] <= mem_addr;
            if (st_m == S_SNWR_WB) begin
              dmr_valid <= 1'b1; dmr_ack <= 1'b1; dmr_dst <= tdid[hit_m]; dmr_addr <= mem_addr;
            end
            tv[hit_m] <= 1'b0; st[mem_addr] <= S_INV;
          end
          default: ;
        endcase
      end else if (dma_take) begin
        tv[free_i] <= 1'b1; ta[free_i] <= dma_addr; tdid[free_i] <= dma_src;
        tdata[free_i] <= dma_data; toff[free_i] <= dma_off; tlen[free_i] <= dma_len;
        if (st_d == S_INV) begin
          mc_valid <= 1'b1; mc_write <= dma_write; mc_addr <= dma_addr; mc_data <= dma_data;
          mc_be <= dma_write ? mask_b(dma_off, dma_len) : '0;
          st[dma_addr] <= dma_write ? S_DWR : S_DRD;
        end else begin
          pv[0] <= 1'b1; pk[0] <= K_INV; pd[0] <= own[dma_addr]; pr[0] <= '0; pa[0] <= dma_addr;
          st[dma_addr] <= dma_write ? S_SNWR : S_SNRD;
        end
      end else if (cpu_take) begin
        if (!is_put) begin
          own[cpu_addr] <= cpu_src;
          if (st_c == S_INV) begin
            mc_valid <= 1'b1; mc_write <= 1'b0; mc_addr <= cpu_addr; mc_be <= '0;
            st[cpu_addr] <= S_FILL;
          end else begin
            pv[0] <= 1'b1; pk[0] <= K_FWD; pd[0] <= own[cpu_addr]; pr[0] <= cpu_src; pa[0] <= cpu_addr;
          end
        end else if (!put_ok) begin
          pv[0] <= 1'b1; pk[0] <= K_NACK; pd[0] <= cpu_src; pr[0] <= '0; pa[0] <= cpu_addr;
        end else begin
          mc_valid <= 1'b1; mc_write <= 1'b1; mc_addr <= cpu_addr; mc_be <= '1;
          mc_data <= (st_c == S_SNWR) ? merge_b(cpu_data, tdata[hit_c], toff[hit_c], tlen[hit_c]) : cpu_data;
          case (st_c)
            S_MOD: begin
              tv[free_i] <= 1'b1; ta[free_i] <= cpu_addr; towner[free_i] <= cpu_src;
              st[cpu_addr] <= S_EVICT;
            end
            S_SNRD: begin
              dmr_valid <= 1'b1; dmr_ack <= 1'b0; dmr_dst <= tdid[hit_c]; dmr_addr <= cpu_addr;
              dmr_data <= cpu_data; towner[hit_c] <= cpu_src; st[cpu_addr] <= S_SNRD_WB;
            end
            default: begin
              towner[hit_c] <= cpu_src; st[cpu_addr] <= S_SNWR_WB;
            end
          endcase
        end
      end
    end
  end

  a_r12_mem_first: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !(dma_take || dma_retry || cpu_take || cpu_retry));
  a_r3_fill_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(mem_valid && !mem_ack));
  a_r13_cmd_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    mc_valid |-> $past(cpu_take || dma_take));
  a_r10_dma_ack_after_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (dmr_valid && dmr_ack) |-> $past(mem_valid && mem_ack));
  a_r9_retry_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_retry || dma_retry) |=> !(mc_valid || rsp_valid || dmr_valid));
  a_r11_table_grow: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tv) <= $countones($past(tv)) + 1);
endmodule

// File: tb/dir_ctrl_tb.sv
module dir_ctrl_tb;
  localparam int CLK_P   = 10;
  localparam int ADDR_W  = 3;
  localparam int CID_W   = 2;
  localparam int DID_W   = 2;
  localparam int LINE_B  = 64;
  localparam int TBE_N   = 4;
  localparam int DIR_LAT = 12;
  localparam int LW      = LINE_B * 8;
  localparam int OW      = $clog2(LINE_B);

  localparam int NV = 6;
  localparam int V_OFF [NV] = '{0, 0, 63, 5, 60, 10};
  localparam int V_LEN [NV] = '{64, 1, 1, 10, 8, 0};
  localparam logic [63:0] V_MASK [NV] = '{64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h8000_0000_0000_0000,
                                          64'h7FE0, 64'hF000_0000_0000_0000, 64'h0};

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic cpu_valid = 0, dma_valid = 0, mem_valid = 0, dma_write = 0, mem_ack = 0;
  logic [1:0] cpu_op = 0;
  logic [CID_W-1:0] cpu_src = 0;
  logic [DID_W-1:0] dma_src = 0;
  logic [ADDR_W-1:0] cpu_addr = 0, dma_addr = 0, mem_addr = 0;
  logic [OW-1:0] dma_off = 0;
  logic [OW:0] dma_len = 0;
  logic [LW-1:0] cpu_data = 0, dma_data = 0, mem_data = 0;
  logic cpu_take, cpu_retry, dma_take, dma_retry;
  logic fwd_valid, rsp_valid, dmr_valid, dmr_ack, mc_valid, mc_write;
  logic [1:0] fwd_kind;
  logic [CID_W-1:0] fwd_dst, fwd_req, rsp_dst;
  logic [DID_W-1:0] dmr_dst;
  logic [ADDR_W-1:0] fwd_addr, rsp_addr, dmr_addr, mc_addr;
  logic [LW-1:0] rsp_data, dmr_data, mc_data;
  logic [LINE_B-1:0] mc_be;

  dir_ctrl #(.ADDR_W(ADDR_W), .CID_W(CID_W), .DID_W(DID_W), .LINE_B(LINE_B), .TBE_N(TBE_N),
             .DIR_LAT(DIR_LAT)) u_dut (
    .clk, .rst_n, .cpu_valid, .cpu_op, .cpu_src, .cpu_addr, .cpu_data, .cpu_take, .cpu_retry,
    .dma_valid, .dma_write, .dma_src, .dma_addr, .dma_off, .dma_len, .dma_data, .dma_take, .dma_retry,
    .mem_valid, .mem_ack, .mem_addr, .mem_data,
    .fwd_valid, .fwd_kind, .fwd_dst, .fwd_req, .fwd_addr,
    .rsp_valid, .rsp_dst, .rsp_addr, .rsp_data,
    .dmr_valid, .dmr_ack, .dmr_dst, .dmr_addr, .dmr_data,
    .mc_valid, .mc_write, .mc_addr, .mc_data, .mc_be);

  int n_chk = 0, n_err = 0;
  logic ct, cr, dt, dr;

  task automatic chk(input string tag, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] ref_merge(input logic [LW-1:0] base, input logic [LW-1:0] over,
                                              input int off, input int len);
    ref_merge = base;
    for (int k = 0; k < len; k++)
      if (off + k < LINE_B) ref_merge[(off+k)*8 +: 8] = over[(off+k)*8 +: 8];
  endfunction

  task automatic fire();
    #1;
    ct = cpu_take; cr = cpu_retry; dt = dma_take; dr = dma_retry;
    @(negedge clk);
    cpu_valid = 0; dma_valid = 0; mem_valid = 0;
  endtask

  task automatic cpu(input logic [1:0] op, input int src, input int a, input logic [LW-1:0] d);
    cpu_valid = 1; cpu_op = op; cpu_src = CID_W'(src); cpu_addr = ADDR_W'(a); cpu_data = d;
    fire();
  endtask

  task automatic dma(input logic wr, input int src, input int a, input int off, input int len,
                     input logic [LW-1:0] d);
    dma_valid = 1; dma_write = wr; dma_src = DID_W'(src); dma_addr = ADDR_W'(a);
    dma_off = OW'(off); dma_len = (OW+1)'(len); dma_data = d;
    fire();
  endtask

  task automatic mem(input logic ack, input int a, input logic [LW-1:0] d);
    mem_valid = 1; mem_ack = ack; mem_addr = ADDR_W'(a); mem_data = d;
    fire();
  endtask

  task automatic wait_fwd(input string tag, input int kind, input int dst, input int req, input int a);
    repeat (DIR_LAT - 2) @(negedge clk);
    chk({tag, " R13 fwd not early"}, LW'(fwd_valid), 0);
    @(negedge clk);
    chk({tag, " R13 fwd on time"}, LW'(fwd_valid), 1);
    chk({tag, " fwd kind"}, LW'(fwd_kind), LW'(kind));
    chk({tag, " fwd dst"}, LW'(fwd_dst), LW'(dst));
    chk({tag, " fwd addr"}, LW'(fwd_addr), LW'(a));
    if (kind == 0) chk({tag, " fwd req"}, LW'(fwd_req), LW'(req));
  endtask

  initial begin
    #(CLK_P * 100000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [LW-1:0] d0, d1, d2, d3, dw, dp;
    d0 = {16{32'hA0A0_0001}}; d1 = {16{32'hB1B1_0002}}; d2 = {16{32'hC2C2_0003}};
    d3 = {16{32'hD3D3_0004}}; dw = {64{8'h5A}};
    for (int b = 0; b < LINE_B; b++) dp[b*8 +: 8] = 8'(b + 1);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset fwd", LW'(fwd_valid), 0);
    chk("R1 reset rsp", LW'(rsp_valid), 0);
    chk("R1 reset dmr", LW'(dmr_valid), 0);
    chk("R1 reset mc", LW'(mc_valid), 0);

    cpu(2'd1, 1, 0, '0);
    chk("R3 fetch taken", LW'(ct), 1);
    chk("R3 R13 mem read", LW'({mc_valid, mc_write, mc_addr}), LW'({1'b1, 1'b0, 3'd0}));
    cpu(2'd0, 2, 0, '0);
    chk("R9 fetch in fill retried", LW'({ct, cr}), 2'b01);
    chk("R9 no cmd on retry", LW'(mc_valid), 0);
    dma(1'b0, 1, 0, 0, 0, '0);
    chk("R9 dma in fill retried", LW'({dt, dr}), 2'b01);
    mem(1'b0, 0, d0);
    chk("R3 fill valid", LW'({rsp_valid, rsp_dst, rsp_addr}), LW'({1'b1, 2'd1, 3'd0}));
    chk("R3 fill data", rsp_data, d0);

    cpu(2'd0, 2, 0, '0);
    chk("R4 fetch in M taken", LW'(ct), 1);
    chk("R4 no mem cmd", LW'(mc_valid), 0);
    wait_fwd("R4", 0, 1, 2, 0);

    cpu(2'd2, 1, 0, d1);
    chk("R2 stale put taken", LW'(ct), 1);
    chk("R2 no mem cmd", LW'(mc_valid), 0);
    wait_fwd("R2 nack in M", 3, 1, 0, 0);

    cpu(2'd2, 2, 0, d1);
    chk("R5 put taken", LW'(ct), 1);
    chk("R5 writeback", LW'({mc_valid, mc_write, mc_addr}), LW'({1'b1, 1'b1, 3'd0}));
    chk("R5 writeback be", LW'(mc_be), {LINE_B{1'b1}});
    chk("R5 writeback data", mc_data, d1);
    cpu(2'd1, 3, 0, '0);
    chk("R9 fetch in evict retried", LW'({ct, cr}), 2'b01);
    mem(1'b1, 0, '0);
    wait_fwd("R5 wb ack", 2, 2, 0, 0);

    cpu(2'd2, 1, 0, d1);
    chk("R2 put in I taken", LW'(ct), 1);
    wait_fwd("R2 nack in I", 3, 1, 0, 0);

    dma(1'b0, 1, 1, 0, 0, '0);
    chk("R6 dma read taken", LW'(dt), 1);
    chk("R6 mem read", LW'({mc_valid, mc_write, mc_addr}), LW'({1'b1, 1'b0, 3'd1}));
    mem(1'b0, 1, d2);
    chk("R6 dma data", LW'({dmr_valid, dmr_ack, dmr_dst, dmr_addr}), LW'({1'b1, 1'b0, 2'd1, 3'd1}));
    chk("R6 dma data value", dmr_data, d2);

    for (int r = 0; r < NV; r++) begin
      logic [LW-1:0] pv;
      pv = {LINE_B{8'(8'h30 + r)}};
      dma(1'b1, 2, 2, V_OFF[r], V_LEN[r], pv);
      chk($sformatf("R7 row %0d taken", r), LW'(dt), 1);
      chk($sformatf("R7 row %0d write", r), LW'({mc_valid, mc_write, mc_addr}), LW'({1'b1, 1'b1, 3'd2}));
      chk($sformatf("R7 row %0d be", r), LW'(mc_be), LW'(V_MASK[r]));
      chk($sformatf("R7 row %0d data", r), mc_data, pv);
      mem(1'b1, 2, '0);
      chk($sformatf("R7 row %0d ack", r), LW'({dmr_valid, dmr_ack, dmr_dst, dmr_addr}),
          LW'({1'b1, 1'b1, 2'd2, 3'd2}));
    end

    cpu(2'd1, 1, 3, '0);
    mem(1'b0, 3, d0);
    dma(1'b0, 3, 3, 0, 0, '0);
    chk("R8 dma read in M taken", LW'(dt), 1);
    chk("R8 no mem cmd", LW'(mc_valid), 0);
    wait_fwd("R8 inv read", 1, 1, 0, 3);
    cpu(2'd1, 2, 3, '0);
    chk("R9 fetch during snoop retried", LW'({ct, cr}), 2'b01);
    cpu(2'd2, 1, 3, d3);
    chk("R8 owner put taken", LW'(ct), 1);
    chk("R8 dma data", LW'({dmr_valid, dmr_ack, dmr_dst, dmr_addr}), LW'({1'b1, 1'b0, 2'd3, 3'd3}));
    chk("R8 dma data value", dmr_data, d3);
    chk("R8 writeback data", mc_data, d3);
    mem(1'b1, 3, '0);
    chk("R10 no dma ack on read", LW'(dmr_valid), 0);
    wait_fwd("R10 wb ack read", 2, 1, 0, 3);

    cpu(2'd1, 0, 4, '0);
    mem(1'b0, 4, d0);
    dma(1'b1, 1, 4, 8, 16, dw);
    chk("R8 dma write in M taken", LW'(dt), 1);
    wait_fwd("R8 inv write", 1, 0, 0, 4);
    cpu(2'd2, 0, 4, dp);
    chk("R8 merged write", LW'({mc_valid, mc_write, mc_addr}), LW'({1'b1, 1'b1, 3'd4}));
    chk("R8 merged data", mc_data, ref_merge(dp, dw, 8, 16));
    mem(1'b1, 4, '0);
    chk("R10 dma ack", LW'({dmr_valid, dmr_ack, dmr_dst, dmr_addr}), LW'({1'b1, 1'b1, 2'd1, 3'd4}));
    wait_fwd("R10 wb ack write", 2, 0, 0, 4);

    dma(1'b0, 0, 5, 0, 0, '0);
    dma(1'b0, 0, 6, 0, 0, '0);
    dma(1'b0, 0, 7, 0, 0, '0);
    dma(1'b0, 0, 0, 0, 0, '0);
    chk("R11 fourth entry taken", LW'(dt), 1);
    dma(1'b0, 2, 1, 0, 0, '0);
    chk("R11 full table retried", LW'({dt, dr}), 2'b01);
    mem(1'b0, 5, d1);
    chk("R11 completion frees", LW'({dmr_valid, dmr_addr}), LW'({1'b1, 3'd5}));
    dma(1'b0, 2, 1, 0, 0, '0);
    chk("R11 retry succeeds", LW'(dt), 1);

    mem_valid = 1; mem_ack = 0; mem_addr = 3'd6; mem_data = d2;
    dma_valid = 1; dma_write = 0; dma_addr = 3'd2; dma_src = 2'd1;
    cpu_valid = 1; cpu_op = 2'd1; cpu_addr = 3'd2; cpu_src = 2'd3;
    fire();
    chk("R12 mem beats dma and cpu", LW'({dt, dr, ct, cr}), 4'b0000);
    chk("R12 mem served", LW'({dmr_valid, dmr_addr}), LW'({1'b1, 3'd6}));
    dma_valid = 1; cpu_valid = 1;
    fire();
    chk("R12 dma beats cpu", LW'({dt, dr, ct, cr}), 4'b1000);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule